// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the read and write addresses that a single DMA channel presents on each data beat. A load pulse captures a read start address, a write start address and the channel's address configuration: the beat size, whether each side steps forward, and an optional power-of-two ring that confines one of the two sides. After the load, every accepted beat moves the enabled addresses forward by the beat size. The side chosen for the ring keeps its upper bits and only cycles through the low bits.

The surrounding channel logic supplies the beats and consumes the two addresses. It handles bus transactions, beat counting and start conditions. A one-cycle strobe marks the cycle in which the outputs show the addresses for the beat just accepted.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst_ni` is low and after it is released, `rd_addr_o` and `wr_addr_o` are 0 and `beat_o` is 0 until the first load or beat.
- R2: A cycle with `load_i` high makes both addresses equal the start inputs on the next cycle. The load wins over a beat in the same cycle, which is then neither applied nor strobed on `beat_o`.
- R3: The beat size field `size_i` is captured at load: 0 means byte (step 1), 1 means halfword (step 2), 2 means word (step 4), and 3 is treated as word (step 4).
- R4: With `rd_incr_i` captured as 0, the read address stays at its start value across beats. With it captured as 1, the read address rises by the step on each accepted beat.
- R5: `wr_incr_i` controls the write address the same way and independently of the read side.
- R6: A captured ring size of 0 applies no wrap: the carry propagates into all address bits.
- R7: A captured ring size n in 1..15 confines the selected address: only bits n-1..0 change, they wrap modulo 2^n, and the bits above keep their load-time value.
- R8: `ring_wr_i` captured as 1 applies the ring to the write address and captured as 0 applies it to the read address. The other address never wraps.
- R9: `beat_o` is high for exactly the one cycle after an accepted beat (`beat_i` high, `load_i` low), and in that cycle the address outputs already reflect that beat.
- R10: Configuration inputs changed without a load have no effect on later beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture start addresses and configuration |
| rd_start_i | input | AW | Read start address |
| wr_start_i | input | AW | Write start address |
| size_i | input | 2 | Beat size: 0 byte, 1 halfword, 2 or 3 word |
| rd_incr_i | input | 1 | Read address steps per beat |
| wr_incr_i | input | 1 | Write address steps per beat |
| ring_size_i | input | RW | Ring width in address bits, 0 disables |
| ring_wr_i | input | 1 | Ring applies to write side (1) or read side (0) |
| beat_i | input | 1 | Beat accepted this cycle |
| rd_addr_o | output | AW | Current read address |
| wr_addr_o | output | AW | Current write address |
| beat_o | output | 1 | Addresses updated for the previous beat |

## Verification
An address register that takes the wrong step or a ring mask that is too wide shows on the address outputs in the cycle after the first affected beat. The bench therefore checks every beat, not only the end of a run. A ring applied to the wrong side, or a mask that is too narrow, first shows when the low bits cross the ring boundary. For that reason the ring tests start a few beats below the boundary and look at the address just after it. A configuration that leaks through without a load only shows after a later beat, so the bench changes the inputs between loads and then issues beats.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_RD   = 0;
  localparam int unsigned SIDE_WR   = 1;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef struct packed {
    logic [1:0] size;
    logic       rd_incr;
    logic       wr_incr;
    logic       ring_wr;
  } addr_cfg_t;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int unsigned AW = 32
) (
  input  logic [1:0]    size_i,
  output logic [AW-1:0] step_o
);
  import dma_addr_pkg::*;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: step_o = AW'(1);
      SZ_HALF: step_o = AW'(2);
      default: step_o = AW'(4); // word and the unused code
    endcase
  end

  always_comb begin
    assert ($onehot(step_o));
  end
endmodule

// File: rtl/dma_addr_ring.sv
module dma_addr_ring #(
  parameter int unsigned AW = 32,
  parameter int unsigned RW = 4,
  parameter int unsigned NS = 2
) (
  input  logic [RW-1:0]        ring_n_i,
  input  logic                 ring_wr_i,
  output logic [NS-1:0][AW-1:0] mask_o
);
  import dma_addr_pkg::*;

  logic [AW-1:0] ring_mask;

  always_comb begin
    if (ring_n_i == '0) ring_mask = '0;
    else                ring_mask = (AW'(1) << ring_n_i) - AW'(1);
  end

  for (genvar s = 0; s < NS; s++) begin : g_side
    localparam logic SEL = (s == int'(SIDE_WR));
    assign mask_o[s] = (ring_wr_i == SEL) ? ring_mask : '0;
  end

  // R8
  always_comb begin
    assert ((mask_o[SIDE_RD] == '0) || (mask_o[SIDE_WR] == '0));
  end
endmodule

// File: rtl/dma_addr_lane.sv
module dma_addr_lane #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  logic          adv_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] mask_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, sum, nxt;

  assign sum = addr_q + step_i;
  // keep bits above the ring, take only the ring bits from the sum
  assign nxt = (mask_i == '0) ? sum : ((addr_q & ~mask_i) | (sum & mask_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= start_i;
    else if (adv_i)  addr_q <= nxt;
  end

  assign addr_o = addr_q;

  // R2
  load_takes_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_q == $past(start_i));

  // R4
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(addr_q));

  // R7
  ring_upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && mask_i != '0) |=>
      ((addr_q & ~$past(mask_i)) == ($past(addr_q) & ~$past(mask_i))));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int unsigned AW = 32,
  parameter int unsigned RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] rd_start_i,
  input  logic [AW-1:0] wr_start_i,
  input  logic [1:0]    size_i,
  input  logic          rd_incr_i,
  input  logic          wr_incr_i,
  input  logic [RW-1:0] ring_size_i,
  input  logic          ring_wr_i,
  input  logic          beat_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          beat_o
);
  import dma_addr_pkg::*;

  localparam int unsigned NS = NUM_SIDES;

  addr_cfg_t     cfg_q;
  logic [RW-1:0] ring_n_q;
  logic          beat_q;
  logic          beat_acc;
  logic [AW-1:0] step;
  logic [NS-1:0][AW-1:0] mask;
  logic [NS-1:0][AW-1:0] start;
  logic [NS-1:0][AW-1:0] addr;
  logic [NS-1:0]         incr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      ring_n_q <= '0;
    end else if (load_i) begin
      cfg_q.size    <= size_i;
      cfg_q.rd_incr <= rd_incr_i;
      cfg_q.wr_incr <= wr_incr_i;
      cfg_q.ring_wr <= ring_wr_i;
      ring_n_q      <= ring_size_i;
    end
  end

  assign beat_acc = beat_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= 1'b0;
    else         beat_q <= beat_acc;
  end

  dma_addr_step #(.AW(AW)) u_step (
    .size_i (cfg_q.size),
    .step_o (step)
  );

  dma_addr_ring #(.AW(AW), .RW(RW), .NS(NS)) u_ring (
    .ring_n_i  (ring_n_q),
    .ring_wr_i (cfg_q.ring_wr),
    .mask_o    (mask)
  );

  assign start[SIDE_RD] = rd_start_i;
  assign start[SIDE_WR] = wr_start_i;
  assign incr[SIDE_RD]  = cfg_q.rd_incr;
  assign incr[SIDE_WR]  = cfg_q.wr_incr;

  for (genvar s = 0; s < NS; s++) begin : g_lane
    dma_addr_lane #(.AW(AW)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load_i),
      .start_i (start[s]),
      .adv_i   (beat_acc && incr[s]),
      .step_i  (step),
      .mask_i  (mask[s]),
      .addr_o  (addr[s])
    );
  end

  assign rd_addr_o = addr[SIDE_RD];
  assign wr_addr_o = addr[SIDE_WR];
  assign beat_o    = beat_q;

  // R9
  beat_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !load_i) |=> beat_o);

  // R2
  load_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !beat_o);

  // R8
  rd_unwrapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_acc && cfg_q.rd_incr && (cfg_q.ring_wr || ring_n_q == '0)) |=>
      rd_addr_o == $past(rd_addr_o) + $past(step));

  // R8
  wr_unwrapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_acc && cfg_q.wr_incr && (!cfg_q.ring_wr || ring_n_q == '0)) |=>
      wr_addr_o == $past(wr_addr_o) + $past(step));
endmodule

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;
  localparam int unsigned AW = 32;
  localparam int unsigned RW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] rd_start = '0;
  logic [AW-1:0] wr_start = '0;
  logic [1:0]    size = '0;
  logic          rd_incr = 1'b0;
  logic          wr_incr = 1'b0;
  logic [RW-1:0] ring_size = '0;
  logic          ring_wr = 1'b0;
  logic          beat = 1'b0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          beat_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_addr_gen #(.AW(AW), .RW(RW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load),
    .rd_start_i(rd_start), .wr_start_i(wr_start), .size_i(size),
    .rd_incr_i(rd_incr), .wr_incr_i(wr_incr),
    .ring_size_i(ring_size), .ring_wr_i(ring_wr),
    .beat_i(beat), .rd_addr_o(rd_addr), .wr_addr_o(wr_addr), .beat_o(beat_out)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                         input logic [1:0] sz, input logic ri, input logic wi,
                         input logic [RW-1:0] rn, input logic rwsel, input logic with_beat);
    @(negedge clk);
    rd_start = ra; wr_start = wa; size = sz; rd_incr = ri; wr_incr = wi;
    ring_size = rn; ring_wr = rwsel; load = 1'b1; beat = with_beat;
    @(negedge clk);
    load = 1'b0; beat = 1'b0;
  endtask

  task automatic do_beat(input string req, input logic [AW-1:0] exp_rd, input logic [AW-1:0] exp_wr);
    @(negedge clk);
    beat = 1'b1;
    @(negedge clk);
    beat = 1'b0;
    check({req, " rd"}, rd_addr, exp_rd);
    check({req, " wr"}, wr_addr, exp_wr);
    check({req, " strobe"}, AW'(beat_out), AW'(1));
  endtask

  task automatic t_reset;
    check("R1 rd", rd_addr, '0);
    check("R1 wr", wr_addr, '0);
    check("R1 strobe", AW'(beat_out), '0);
  endtask

  task automatic t_load_override;
    do_load(32'h0000_1000, 32'h0000_2000, 2'd2, 1'b1, 1'b1, '0, 1'b0, 1'b1);
    check("R2 rd", rd_addr, 32'h0000_1000);
    check("R2 wr", wr_addr, 32'h0000_2000);
    check("R2 no strobe", AW'(beat_out), '0);
    do_beat("R9", 32'h0000_1004, 32'h0000_2004);
    @(negedge clk);
    check("R9 single", AW'(beat_out), '0);
  endtask

  task automatic t_sizes;
    logic [AW-1:0] stp;
    for (int sz = 0; sz < 4; sz++) begin
      stp = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      do_load(32'h0000_0100, 32'h0000_0200, 2'(sz), 1'b1, 1'b1, '0, 1'b0, 1'b0);
      do_beat("R3", 32'h0000_0100 + stp, 32'h0000_0200 + stp);
      do_beat("R3", 32'h0000_0100 + 2*stp, 32'h0000_0200 + 2*stp);
    end
  endtask

  task automatic t_incr;
    do_load(32'h0000_1000, 32'h0000_2000, 2'd2, 1'b0, 1'b1, '0, 1'b0, 1'b0);
    do_beat("R4", 32'h0000_1000, 32'h0000_2004);
    do_beat("R4", 32'h0000_1000, 32'h0000_2008);
    do_load(32'h0000_1000, 32'h0000_2000, 2'd2, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    do_beat("R5", 32'h0000_1004, 32'h0000_2000);
    do_beat("R5", 32'h0000_1008, 32'h0000_2000);
  endtask

  task automatic t_ring_off;
    do_load(32'h0000_FFFC, 32'h0000_00FE, 2'd2, 1'b1, 1'b1, '0, 1'b1, 1'b0);
    do_beat("R6", 32'h0001_0000, 32'h0000_0102);
  endtask

  task automatic t_ring_rd;
    do_load(32'h1230_00F8, 32'h1230_00F8, 2'd2, 1'b1, 1'b1, 4'd4, 1'b0, 1'b0);
    do_beat("R7", 32'h1230_00FC, 32'h1230_00FC);
    do_beat("R7", 32'h1230_00F0, 32'h1230_0100);
    do_beat("R8", 32'h1230_00F4, 32'h1230_0104);
  endtask

  task automatic t_ring_wr;
    do_load(32'h0000_0046, 32'hABCD_0046, 2'd1, 1'b1, 1'b1, 4'd3, 1'b1, 1'b0);
    do_beat("R8", 32'h0000_0048, 32'hABCD_0040);
    do_beat("R7", 32'h0000_004A, 32'hABCD_0042);
    do_load(32'h0000_7FFE, 32'h0001_7FFE, 2'd0, 1'b1, 1'b1, 4'd15, 1'b1, 1'b0);
    do_beat("R7", 32'h0000_7FFF, 32'h0001_7FFF);
    do_beat("R7", 32'h0000_8000, 32'h0001_0000);
  endtask

  task automatic t_cfg_hold;
    do_load(32'h0000_0300, 32'h0000_0400, 2'd0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    @(negedge clk);
    size = 2'd2; rd_incr = 1'b0; wr_incr = 1'b1; ring_size = 4'd1; ring_wr = 1'b0;
    do_beat("R10", 32'h0000_0301, 32'h0000_0400);
    do_beat("R10", 32'h0000_0302, 32'h0000_0400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_override();
    t_sizes();
    t_incr();
    t_ring_off();
    t_ring_rd();
    t_ring_wr();
    t_cfg_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule